// File: doc/BRIEF.md
# Zero-Crossing-Timed Transformer Tap Selector

This block chooses between two turns ratios of the isolation transformer in a high-frequency-link inverter. It compares a digitized input-voltage word against a switch-over point of about 42 V. Low input voltages get the higher ratio (6.5) and higher input voltages get the lower ratio (4.3). A hysteresis band around the switch-over point keeps the choice from chattering. The choice drives one relay command. The operating modes of the power stage are the same for either setting, so the relay is the only thing the choice changes.

A requested change is never applied at the instant the threshold is crossed. It is held as pending and applied only when the signed line-frequency reference is near a zero crossing, where little power flows and the relay contacts see little inrush. A zero crossing is a sign change between consecutive reference samples, or a reference magnitude inside a small window. After each relay change, further changes are locked out until a set number of line half-cycles have passed, which gives the relay time to settle.

Thresholds, hysteresis, window size, lockout length and relay polarity are parameters. The bench uses the default values: voltage code 420 for the threshold, 5 for the hysteresis, 20 for the window and 2 half-cycles of lockout. Input voltages are codes of 0.1 V per LSB.

Top module: `tap_selector`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `ratio_low` is 0 (high ratio selected), `change_pending` is 0 and `relay_on` is inactive.
- R2: With the high ratio requested, a valid sample strictly above THRESH+HYST (code 425) requests the low ratio. If this differs from the applied ratio, `change_pending` is 1 from the next cycle on.
- R3: With the low ratio requested, only a valid sample strictly below THRESH-HYST (code 415) requests the high ratio again. Samples from 415 to 425 inclusive leave the request unchanged. A request withdrawn before it is applied clears `change_pending`.
- R4: A zero crossing is either a change of `line_ref` bit LW-1 (the sign) between the previous and the current sample, or |`line_ref`| ≤ ZC_WIN (20). A pending change with the enable high and no lockout is applied one cycle after such a sample.
- R5: `change_pending` is 1 exactly when the requested ratio differs from the applied one. The applied ratio never changes in a cycle that follows a sample without a zero crossing.
- R6: A voltage word presented with `vin_valid` low has no effect on the request.
- R7: While `en` is 0 no pending change is applied, even at a zero crossing. The request still follows valid samples.
- R8: After a ratio change, no further change is applied until LOCK_HALF (2) sign changes of `line_ref` have been seen. A change may be applied at any zero crossing after the LOCK_HALF-th sign change. The sample carrying that sign change itself cannot apply a change.
- R9: `relay_on` equals `ratio_low` when RELAY_INV is 0 (default) and its inverse otherwise. `relay_on` changes in the same cycle as `ratio_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Permits pending changes to be applied |
| vin_sample | input | VW | Input-voltage code, 0.1 V per LSB |
| vin_valid | input | 1 | Qualifies `vin_sample` |
| line_ref | input | LW | Signed line-frequency reference sample, one per cycle |
| relay_on | output | 1 | Relay command, polarity set by RELAY_INV |
| ratio_low | output | 1 | 1 when the low ratio (4.3) is applied, 0 for the high ratio (6.5) |
| change_pending | output | 1 | Requested ratio differs from the applied one |

## Verification
The hardest situation to reach is the end of the lockout. The bench needs a pending request, a lockout that is still running, and a zero crossing that arrives exactly on the sign change that ends the lockout and so must be refused. After that it needs a window-only crossing that is accepted. The stimulus reaches this by alternating `line_ref` between ±500 and small in-window values after each applied change, and by issuing a new voltage request while the lockout is counting. A further sequence makes the sign change while `en` is low and then offers a negative in-window sample with no sign change. This shows that the magnitude window alone can trigger a change. Samples at 415 and 425 and line values of ±20 and -21 probe the boundaries of the hysteresis band and of the window.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;
   typedef enum logic {
      RATIO_HIGH = 1'b0,
      RATIO_LOW  = 1'b1
   } ratio_e;
endpackage

// File: rtl/tap_vin_cmp.sv
// Input-voltage comparator with a hysteresis band; holds the requested ratio.
module tap_vin_cmp
   import tap_sel_pkg::*;
#(
   parameter int VW     = 10,
   parameter int THRESH = 420,
   parameter int HYST   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] sample,
   input  logic          valid,
   output ratio_e        want
);
   localparam logic [VW-1:0] UP_C = VW'(THRESH + HYST);
   localparam logic [VW-1:0] DN_C = VW'(THRESH - HYST);

   ratio_e want_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_q <= RATIO_HIGH;
      end else if (valid) begin
         if (want_q == RATIO_HIGH && sample > UP_C) begin
            want_q <= RATIO_LOW;
         end else if (want_q == RATIO_LOW && sample < DN_C) begin
            want_q <= RATIO_HIGH;
         end
      end
   end

   assign want = want_q;
endmodule

// File: rtl/tap_zc_det.sv
// Zero-crossing detector: sign change against previous sample, or small magnitude.
module tap_zc_det #(
   parameter int LW     = 12,
   parameter int ZC_WIN = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [LW-1:0] line,
   output logic                 zc_hit,
   output logic                 sign_flip
);
   localparam int            MW    = LW + 1;
   localparam logic [MW-1:0] WIN_C = MW'(ZC_WIN);

   logic          prev_sign;
   logic          prev_vld;
   logic [MW-1:0] ext;
   logic [MW-1:0] mag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sign <= 1'b0;
         prev_vld  <= 1'b0;
      end else begin
         prev_sign <= line[LW-1];
         prev_vld  <= 1'b1;
      end
   end

   always_comb begin
      ext = {line[LW-1], line};
      mag = line[LW-1] ? (~ext + MW'(1)) : ext;
   end

   assign sign_flip = prev_vld && (prev_sign != line[LW-1]);
   assign zc_hit    = sign_flip || (mag <= WIN_C);
endmodule

// File: rtl/tap_lockout.sv
// Half-cycle lockout counter armed by each ratio change.
module tap_lockout #(
   parameter int LOCK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic tick,
   output logic active
);
   localparam int CW = (LOCK_HALF < 2) ? 1 : $clog2(LOCK_HALF + 1);
   localparam logic [CW-1:0] LOAD_C = CW'(LOCK_HALF);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (arm) begin
         cnt <= LOAD_C;
      end else if (tick && cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/tap_selector.sv
// Transformer tap selector: applies ratio changes only at line zero crossings.
module tap_selector
   import tap_sel_pkg::*;
#(
   parameter int VW        = 10,
   parameter int LW        = 12,
   parameter int THRESH    = 420,
   parameter int HYST      = 5,
   parameter int ZC_WIN    = 20,
   parameter int LOCK_HALF = 2,
   parameter bit RELAY_INV = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [VW-1:0]        vin_sample,
   input  logic                 vin_valid,
   input  logic signed [LW-1:0] line_ref,
   output logic                 relay_on,
   output logic                 ratio_low,
   output logic                 change_pending
);
   if (HYST < 0 || HYST >= THRESH) begin : g_bad_hyst
      $error("tap_selector: HYST must lie in 0..THRESH-1");
   end
   if (THRESH + HYST >= (1 << VW)) begin : g_bad_thr
      $error("tap_selector: THRESH+HYST does not fit in VW bits");
   end
   if (ZC_WIN < 0 || ZC_WIN >= (1 << (LW - 1))) begin : g_bad_win
      $error("tap_selector: ZC_WIN out of range for LW");
   end
   if (LOCK_HALF < 1) begin : g_bad_lock
      $error("tap_selector: LOCK_HALF must be at least 1");
   end

   ratio_e want;
   ratio_e applied_q;
   logic   zc_hit;
   logic   sign_flip;
   logic   lock_active;
   logic   apply;

   tap_vin_cmp #(.VW(VW), .THRESH(THRESH), .HYST(HYST)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (vin_sample),
      .valid  (vin_valid),
      .want   (want)
   );

   tap_zc_det #(.LW(LW), .ZC_WIN(ZC_WIN)) u_zc (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (line_ref),
      .zc_hit    (zc_hit),
      .sign_flip (sign_flip)
   );

   assign apply = en && (want != applied_q) && zc_hit && !lock_active;

   tap_lockout #(.LOCK_HALF(LOCK_HALF)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (apply),
      .tick   (sign_flip),
      .active (lock_active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         applied_q <= RATIO_HIGH;
      end else if (apply) begin
         applied_q <= want;
      end
   end

   assign ratio_low      = (applied_q == RATIO_LOW);
   assign change_pending = (want != applied_q);

   if (RELAY_INV) begin : g_relay_inv
      assign relay_on = ~ratio_low;
   end else begin : g_relay_dir
      assign relay_on = ratio_low;
   end
endmodule

// File: rtl/tap_selector_chk.sv
// Property checker bound into tap_selector.
module tap_selector_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic vin_valid,
   input logic ratio_low,
   input logic change_pending,
   input logic zc_hit,
   input logic lock_active
);
   // R1: reset forces the high ratio with nothing pending
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!ratio_low && !change_pending));

   // R5: a ratio change only follows a zero-crossing sample
   a_r5_change_at_zc: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_low != $past(ratio_low)) |-> $past(zc_hit));

   // R7: disabled block keeps its ratio
   a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(ratio_low));

   // R8: no change while the lockout runs
   a_r8_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> $stable(ratio_low));

   // R6: without a valid sample pending only moves when the ratio is applied
   a_r6_no_sample_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      !vin_valid |=> ($stable(change_pending) || !$stable(ratio_low)));
endmodule

bind tap_selector tap_selector_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .en             (en),
   .vin_valid      (vin_valid),
   .ratio_low      (ratio_low),
   .change_pending (change_pending),
   .zc_hit         (zc_hit),
   .lock_active    (lock_active)
);

// File: tb/tap_selector_test.sv
module tap_selector_test;
   typedef struct {
      logic  r;
      logic  p;
      string tag;
   } exp_t;

   logic              clk;
   logic              rst_n;
   logic              en;
   logic [9:0]        vin_sample;
   logic              vin_valid;
   logic signed [11:0] line_ref;
   logic              relay_on;
   logic              ratio_low;
   logic              change_pending;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 0;
   exp_t q[$];
   exp_t e;

   tap_selector uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .en             (en),
      .vin_sample     (vin_sample),
      .vin_valid      (vin_valid),
      .line_ref       (line_ref),
      .relay_on       (relay_on),
      .ratio_low      (ratio_low),
      .change_pending (change_pending)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic compare(input logic r, input logic p, input string tag);
      n_chk++;
      if (ratio_low !== r || change_pending !== p || relay_on !== r) begin
         n_fail++;
         $display("FAIL %s: ratio_low=%b pending=%b relay=%b expected ratio_low=%b pending=%b relay=%b",
                  tag, ratio_low, change_pending, relay_on, r, p, r);
      end
   endtask

   // Driver: apply inputs at the falling edge and queue the expected result
   task automatic step(input int vin, input bit vv, input int line, input bit ena,
                       input logic er, input logic ep, input string tag);
      exp_t it;
      @(negedge clk);
      vin_sample = 10'(vin);
      vin_valid  = vv;
      line_ref   = 12'(line);
      en         = ena;
      it.r   = er;
      it.p   = ep;
      it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: compare just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            compare(e.r, e.p, e.tag);
         end
      end
   end

   initial begin
      rst_n = 1'b0; en = 1'b1; vin_sample = '0; vin_valid = 1'b0; line_ref = 12'sd500;
      repeat (3) @(negedge clk);
      compare(1'b0, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      step(0,   0,  500, 1, 0, 0, "R1 after release");
      step(430, 1,  500, 1, 0, 1, "R2 request low");
      step(0,   0,  500, 1, 0, 1, "R5 held without crossing");
      step(0,   0, -500, 0, 0, 1, "R7 crossing while disabled");
      step(0,   0, -500, 1, 0, 1, "R5 no crossing");
      step(0,   0,   10, 1, 1, 0, "R4 sign change applies, R9 relay");
      step(410, 1,  500, 1, 1, 1, "R3 request high");
      step(0,   0,    5, 1, 1, 1, "R8 window during lockout");
      step(0,   0, -500, 1, 1, 1, "R8 first half-cycle");
      step(0,   0,  500, 1, 1, 1, "R8 second half-cycle blocked");
      step(0,   0,    8, 1, 0, 0, "R8 applied after lockout");
      step(418, 1,  500, 1, 0, 0, "R3 inside band");
      step(425, 1,  500, 1, 0, 0, "R3 upper edge");
      step(426, 1,  500, 1, 0, 1, "R2 above band");
      step(418, 1,  500, 1, 0, 1, "R3 band keeps low request");
      step(415, 1,  500, 1, 0, 1, "R3 lower edge");
      step(414, 1,  500, 1, 0, 0, "R3 withdrawn");
      step(600, 0,  500, 1, 0, 0, "R6 invalid sample");
      step(0,   0, -500, 1, 0, 0, "R8 burn half-cycle");
      step(0,   0,  500, 1, 0, 0, "R8 burn half-cycle");
      step(500, 1,  500, 1, 0, 1, "R2 request low again");
      step(0,   0, -500, 0, 0, 1, "R7 sign change while disabled");
      step(0,   0,  -20, 1, 1, 0, "R4 negative window edge");
      step(0,   0,  500, 1, 1, 0, "R8 half-cycle");
      step(0,   0, -500, 1, 1, 0, "R8 half-cycle");
      step(400, 1, -500, 1, 1, 1, "R3 request high");
      step(0,   0,  -21, 1, 1, 1, "R4 just outside window");
      step(0,   0,  -19, 1, 0, 0, "R4 inside window applies");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule